// File: doc/BRIEF.md
# Receive Queue Interrupt Request Generator

This block sits between a serial receiver and the processor that drains it. The receiver pushes each byte into an eight-entry queue, together with a small vector of error flags for that byte. The processor pops entries from the head of the queue. It sees the head byte and its flags at all times, plus a flag that says data is waiting. Two registered request lines tell an interrupt controller when the queue wants attention. One is a character request and the other is a special-condition request. Both are silenced while the controller reports that a receive interrupt is in service.

A two-bit mode input selects how requests are raised. In mode 0 requests are off. In mode 1 only the first character is signalled. Mode 2 signals every character and every special condition. Mode 3 signals special conditions only. A batching option applies in mode 2 only. With batching on, the character request waits until four bytes are queued and none of them is flagged. Any flagged byte among the four oldest entries raises the special-condition request at once, even before that byte reaches the head. The queue is never frozen by an error, so software reads each entry's flags before its byte and needs no error-clearing step.

Top module: `rx_irq_fifo`

## Requirements
- R1: The queue holds up to eight entries and returns them in arrival order; `rd_data`/`rd_err` always show the oldest entry, and a pop while empty is ignored.
- R2: `data_avail` is high exactly when at least one entry is queued, in every mode and whatever `thresh_en` is.
- R3: A push while eight entries are queued and no pop is presented is discarded and sets the sticky `overrun` flag; `ovr_clr` clears it, except in a cycle that itself overruns, where the set wins.
- R4: A push and a pop in the same cycle leave the count unchanged, including when the queue is full; the pushed entry is kept.
- R5: Both request outputs are registered: the value seen after a clock edge is computed from the queue state, mode, `thresh_en` and `in_service` present just before that edge.
- R6: While `in_service` is high at an edge, both requests are low after that edge.
- R7: In mode 0 (off) no request is raised, while `data_avail`, head data and `overrun` keep updating.
- R8: In mode 2 with `thresh_en` low, the character request is raised whenever the queue is non-empty, and the special request whenever the head entry has a non-zero error vector.
- R9: In mode 2 with `thresh_en` high, the character request is raised only when four or more entries are queued and none of the four oldest has a non-zero error vector.
- R10: In mode 2 with `thresh_en` high, the special request is raised when any of the four oldest queued entries (fewer if fewer are queued) has a non-zero error vector, whatever its distance from the head.
- R11: In mode 2 with `thresh_en` high, when `in_service` drops while four or more clean entries remain, the character request is raised again one edge later.
- R12: `thresh_en` has no effect in modes 1 and 3.
- R13: In mode 1 (first character), the character request is raised while the queue is non-empty and an arm flag is set. The flag is set at reset and at every edge where the queue is empty, and cleared at an edge where `in_service` is high with data queued. The special request follows the head entry's error vector.
- R14: In mode 3 (special only), the character request stays low and the special request follows the head entry's error vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Receiver writes an entry |
| push_data | input | DW | Received byte |
| push_err | input | EW | Error flags of the received byte (non-zero = special condition) |
| pop | input | 1 | Processor removes the head entry |
| mode | input | 2 | 0 off, 1 first character, 2 all characters, 3 special only |
| thresh_en | input | 1 | Four-byte batching, effective in mode 2 only |
| in_service | input | 1 | Receive interrupt currently in service |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | DW | Head byte |
| rd_err | output | EW | Head error flags |
| data_avail | output | 1 | At least one entry queued |
| overrun | output | 1 | Sticky: an entry was lost |
| irq_char | output | 1 | Character-available request |
| irq_spec | output | 1 | Special-condition request |

## Verification
A push and a pop can land on the same edge, and this matters most when the queue is full. The pop must free the slot that the push fills, with no overrun and no lost entry. The bench forces this with a directed full-queue burst. It then drains the queue and compares every byte against a queue model. It also repeats the overlap thousands of times under random traffic with mode switches. The overrun set and its clear can also meet in one cycle, and the model decides that case by letting the set win.

// File: rtl/rx_irq_fifo.sv
module rx_irq_fifo #(
  parameter int DEPTH  = 8,
  parameter int DW     = 8,
  parameter int EW     = 3,
  parameter int THRESH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic [EW-1:0] push_err,
  input  logic          pop,
  input  logic [1:0]    mode,
  input  logic          thresh_en,
  input  logic          in_service,
  input  logic          ovr_clr,
  output logic [DW-1:0] rd_data,
  output logic [EW-1:0] rd_err,
  output logic          data_avail,
  output logic          overrun,
  output logic          irq_char,
  output logic          irq_spec
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] M_OFF   = 2'd0;
  localparam logic [1:0] M_FIRST = 2'd1;
  localparam logic [1:0] M_ALL   = 2'd2;
  localparam logic [1:0] M_SPEC  = 2'd3;
  localparam logic [CW-1:0] C_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] C_THR  = CW'(THRESH);

  logic [DW-1:0] dmem [DEPTH];
  logic [EW-1:0] emem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic          armed;

  wire empty   = (count == '0);
  wire full    = (count == C_FULL);
  wire do_pop  = pop && !empty;
  wire do_push = push && (!full || do_pop);
  wire ovf     = push && full && !pop;

  function automatic logic [AW-1:0] wrap(input logic [AW-1:0] p, input int unsigned k);
    int unsigned s;
    s = (int'(p) + k) % DEPTH;
    return AW'(s);
  endfunction

  assign rd_data    = dmem[rd_ptr];
  assign rd_err     = emem[rd_ptr];
  assign data_avail = !empty;

  logic [THRESH-1:0] win_err;
  for (genvar i = 0; i < THRESH; i++) begin : g_win
    assign win_err[i] = (count > CW'(i)) && (|emem[wrap(rd_ptr, i)]);
  end

  wire head_err = !empty && (|rd_err);
  wire thr_on   = thresh_en && (mode == M_ALL);

  logic char_req, spec_req;
  always_comb begin
    char_req = 1'b0;
    spec_req = 1'b0;
    unique case (mode)
      M_OFF: ;
      M_FIRST: begin
        char_req = armed && !empty;
        spec_req = head_err;
      end
      M_ALL: begin
        if (thr_on) begin
          char_req = (count >= C_THR) && !(|win_err);
          spec_req = |win_err;
        end else begin
          char_req = !empty;
          spec_req = head_err;
        end
      end
      M_SPEC: spec_req = head_err;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      dmem[wr_ptr] <= push_data;
      emem[wr_ptr] <= push_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      count    <= '0;
      armed    <= 1'b1;
      overrun  <= 1'b0;
      irq_char <= 1'b0;
      irq_spec <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= wrap(wr_ptr, 1);
      if (do_pop)  rd_ptr <= wrap(rd_ptr, 1);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (ovf)          overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      if (empty)                               armed <= 1'b1;
      else if (in_service && mode == M_FIRST)  armed <= 1'b0;
      irq_char <= char_req && !in_service;
      irq_spec <= spec_req && !in_service;
    end
  end

  a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= C_FULL);
  a_r2_push_avail: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_avail);
  a_r3_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> overrun);
  a_r4_pushpop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(count));
  a_r6_in_service_gate: assert property (@(posedge clk) disable iff (!rst_n)
    in_service |=> (!irq_char && !irq_spec));
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |=> (!irq_char && !irq_spec));
  a_r14_spec_no_char: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SPEC) |=> !irq_char);
endmodule

// File: tb/rx_irq_fifo_tb.sv
module rx_irq_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_i = 1'b0, pop_i = 1'b0, thresh_i = 1'b0, in_srv = 1'b0, clr_i = 1'b0;
  logic [7:0] data_i = '0;
  logic [2:0] err_i = '0;
  logic [1:0] mode_i = 2'd2;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic       data_avail, overrun, irq_char, irq_spec;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #4 clk = ~clk;

  rx_irq_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .push(push_i), .push_data(data_i), .push_err(err_i),
    .pop(pop_i), .mode(mode_i), .thresh_en(thresh_i), .in_service(in_srv),
    .ovr_clr(clr_i), .rd_data(rd_data), .rd_err(rd_err), .data_avail(data_avail),
    .overrun(overrun), .irq_char(irq_char), .irq_spec(irq_spec)
  );

  logic [10:0] mq[$];
  bit m_ovr = 0, m_armed = 1, e_char = 0, e_spec = 0;
  bit c, s, win, headf, thr, popok;
  int n;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_ovr = 0; m_armed = 1; e_char = 0; e_spec = 0;
    end else begin
      n = mq.size();
      thr = thresh_i && mode_i == 2'd2;
      win = 0;
      for (int i = 0; i < 4 && i < n; i++) if (mq[i][10:8] != 0) win = 1;
      headf = n > 0 && mq[0][10:8] != 0;
      c = 0; s = 0;
      case (mode_i)
        2'd1: begin c = m_armed && n > 0; s = headf; end
        2'd2: if (thr) begin c = n >= 4 && !win; s = win; end
              else begin c = n > 0; s = headf; end
        2'd3: s = headf;
        default: ;
      endcase
      e_char = c && !in_srv;
      e_spec = s && !in_srv;
      if (n == 0) m_armed = 1;
      else if (in_srv && mode_i == 2'd1) m_armed = 0;
      popok = pop_i && n > 0;
      if (popok) void'(mq.pop_front());
      if (push_i && (n < 8 || popok)) mq.push_back({err_i, data_i});
      if (push_i && n == 8 && !pop_i) m_ovr = 1;
      else if (clr_i) m_ovr = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s) actual %0h expected %0h", tag, phase, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 data_avail", int'(data_avail), int'(mq.size() > 0));
    chk("R3 overrun", int'(overrun), int'(m_ovr));
    if (mq.size() > 0) chk("R1 head", int'({rd_err, rd_data}), int'(mq[0]));
    chk("R5 irq_char", int'(irq_char), int'(e_char));
    chk("R5 irq_spec", int'(irq_spec), int'(e_spec));
  endtask

  task automatic step(input bit p, input logic [7:0] d, input logic [2:0] e, input bit q);
    push_i = p; data_i = d; err_i = e; pop_i = q;
    @(negedge clk);
    compare();
    push_i = 0; pop_i = 0; clr_i = 0;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 8'h00, 3'd0, 0);
  endtask

  task automatic drain();
    while (mq.size() > 0) step(0, 8'h00, 3'd0, 1);
    idle(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    phase = "R1 reset";
    @(negedge clk);
    compare();

    phase = "R8 all-chars";
    mode_i = 2'd2; thresh_i = 0;
    step(1, 8'h11, 3'd0, 0);
    step(1, 8'h22, 3'd4, 0);
    idle(2);
    step(0, 8'h00, 3'd0, 1);
    idle(2);
    drain();

    phase = "R3 overrun";
    for (int i = 0; i < 9; i++) step(1, 8'h40 + 8'(i), 3'd0, 0);
    idle(1);
    phase = "R4 push-pop full";
    step(1, 8'hA5, 3'd0, 1);
    step(1, 8'hA6, 3'd0, 1);
    phase = "R3 clear";
    clr_i = 1; step(0, 8'h00, 3'd0, 0);
    phase = "R3 set beats clear";
    clr_i = 1; step(1, 8'hEE, 3'd0, 0);
    clr_i = 1; step(0, 8'h00, 3'd0, 0);
    phase = "R4 drain";
    drain();

    phase = "R9 threshold";
    thresh_i = 1;
    for (int i = 0; i < 3; i++) step(1, 8'h60 + 8'(i), 3'd0, 0);
    idle(1);
    step(1, 8'h63, 3'd0, 0);
    idle(2);
    phase = "R6 in-service";
    in_srv = 1; step(1, 8'h64, 3'd0, 0);
    idle(2);
    phase = "R11 re-request";
    in_srv = 0; idle(2);
    drain();
    phase = "R10 early special";
    step(1, 8'h70, 3'd0, 0);
    step(1, 8'h71, 3'd0, 0);
    step(1, 8'h72, 3'd2, 0);
    idle(2);
    step(1, 8'h73, 3'd0, 0);
    idle(1);
    drain();
    phase = "R10 beyond window";
    for (int i = 0; i < 4; i++) step(1, 8'h80 + 8'(i), 3'd0, 0);
    step(1, 8'h84, 3'd1, 0);
    idle(2);
    step(0, 8'h00, 3'd0, 1);
    idle(2);
    drain();

    phase = "R7 off";
    mode_i = 2'd0;
    step(1, 8'h90, 3'd7, 0);
    step(1, 8'h91, 3'd0, 0);
    idle(2);
    drain();

    phase = "R13 first-char";
    mode_i = 2'd1; thresh_i = 1;
    step(1, 8'hB0, 3'd0, 0);
    idle(2);
    in_srv = 1; step(1, 8'hB1, 3'd0, 0);
    in_srv = 0; idle(2);
    phase = "R12 first-char thresh";
    step(1, 8'hB2, 3'd3, 0);
    step(0, 8'h00, 3'd0, 1);
    step(0, 8'h00, 3'd0, 1);
    idle(2);
    drain();
    phase = "R13 rearm";
    step(1, 8'hB3, 3'd0, 0);
    idle(2);
    drain();

    phase = "R14 special-only";
    mode_i = 2'd3; thresh_i = 1;
    step(1, 8'hC0, 3'd0, 0);
    step(1, 8'hC1, 3'd5, 0);
    idle(2);
    phase = "R12 special-only thresh";
    step(0, 8'h00, 3'd0, 1);
    idle(2);
    drain();

    phase = "R5 random";
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) begin
        mode_i = 2'($urandom_range(0, 3));
        thresh_i = 1'($urandom_range(0, 1));
      end
      in_srv = ($urandom_range(0, 9) == 0);
      clr_i = ($urandom_range(0, 19) == 0);
      step(($urandom_range(0, 99) < 55), 8'($urandom),
           ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'd0,
           ($urandom_range(0, 99) < 45));
    end
    in_srv = 0;
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule